// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower word-wide memory. It holds lines of four words in two ways per set. Each request looks up the selected set in both ways in parallel. A request that matches a valid way is answered combinationally in the same cycle. A request that matches neither way stalls the requester. The block then fetches the whole line from memory, one word per acknowledge, into a victim way. The victim is an empty way if the set has one; otherwise it is the way used least recently.

Its total capacity equals that of a direct-mapped cache with twice the sets. The index is therefore one bit narrower and the tag one bit wider. One replacement bit per set records which way is to be replaced next. The requester keeps its request and address asserted while stalled. Once the fill completes, the held request hits and is answered.

Top module: `sa_cache`

## Requirements
- R1: The address is split, from most to least significant, as tag | set index (SET_W bits, at bits [SET_W+3:4]) | word select (bits [3:2]) | byte offset (bits [1:0]). The byte offset has no effect on the returned word. Lines at different set indices do not disturb each other.
- R2: A request whose tag matches a valid way of its set asserts resp_o in the same cycle, with stall_o low and no memory request. rdata_o carries the selected word of that line.
- R3: A request that matches no valid way asserts stall_o with resp_o low, from the request cycle until the fill has finished.
- R4: A fill issues exactly four memory reads in ascending order. Their word addresses are the line base plus 0, 4, 8 and 12, with the byte bits zero. Each address and mem_req_o are held until mem_ack_i is seen, and the word is captured from mem_rdata_i in the acknowledge cycle.
- R5: In the cycle after the fourth acknowledge, the held request hits and returns the fetched word.
- R6: A miss fills an invalid way first: way 0 if both are invalid, else the invalid one. Two different tags in one set therefore both stay resident.
- R7: When both ways of a set are valid, a miss replaces the way not touched most recently. A hit or a fill counts as a touch.
- R8: An active-low asynchronous reset clears every valid bit and replacement bit. Afterwards stall_o, resp_o and mem_req_o are low while idle, and any earlier resident line misses.
- R9: At most one way of a set matches a given request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, held while stall_o is high |
| addr_i | input | ADDR_W | Byte address of the request |
| stall_o | output | 1 | Requester must wait |
| resp_o | output | 1 | rdata_o is valid for the current request |
| rdata_o | output | DATA_W | Requested word |
| mem_req_o | output | 1 | Memory read request during a fill |
| mem_addr_o | output | ADDR_W | Word address of the memory read |
| mem_ack_i | input | 1 | Memory returns mem_rdata_i this cycle |
| mem_rdata_i | input | DATA_W | Word from memory |

## Verification
The assertions rely on the requester keeping req_i and addr_i unchanged while stall_o is high. The check that the cycle after the last acknowledge is a hit depends on this. The bench drives each access at a falling edge and holds it until resp_o is seen. Its memory model acknowledges only while mem_req_o is high, after a chosen wait of zero to three cycles, and never acknowledges twice in a row. This keeps the acknowledge timing within what the fill sequence expects.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  localparam int NUM_WAYS = 2;
  typedef enum logic {ST_IDLE, ST_FILL} fill_state_e;
endpackage

// File: rtl/sa_cache_way.sv
module sa_cache_way #(
  parameter int TAG_W  = 26,
  parameter int SET_W  = 2,
  parameter int WOFF_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic [WOFF_W-1:0] rd_word_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [WOFF_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic [TAG_W-1:0]  commit_tag_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << WOFF_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS][WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (commit_i) valid_q[wr_set_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) tag_q[wr_set_i] <= commit_tag_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_set_i][wr_word_i] <= wr_data_i;
  end

  always_comb begin
    valid_o = valid_q[rd_set_i];
    hit_o   = valid_o && (tag_q[rd_set_i] == cmp_tag_i);
    rdata_o = data_q[rd_set_i][rd_word_i];
  end
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int SET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic             repl_way_o,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic             touch_way_i
);
  localparam int SETS = 1 << SET_W;

  // each bit names the way to replace next in its set
  logic [SETS-1:0] repl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) repl_q <= '0;
    else if (touch_en_i) repl_q[touch_set_i] <= ~touch_way_i;
  end

  assign repl_way_o = repl_q[rd_set_i];
endmodule

// File: rtl/sa_cache_ctrl.sv
module sa_cache_ctrl
  import sa_cache_pkg::*;
#(
  parameter int LINE_W = 28,
  parameter int WOFF_W = 2,
  parameter int BYTE_W = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            lookup_hit_i,
  input  logic [LINE_W-1:0]               line_i,
  input  logic                            victim_i,
  input  logic                            mem_ack_i,
  output logic                            stall_o,
  output logic                            resp_o,
  output logic                            mem_req_o,
  output logic [LINE_W+WOFF_W+BYTE_W-1:0] mem_addr_o,
  output logic                            wr_en_o,
  output logic [WOFF_W-1:0]               wr_word_o,
  output logic                            commit_o,
  output logic [LINE_W-1:0]               fill_line_o,
  output logic                            fill_way_o
);
  localparam logic [WOFF_W-1:0] LAST_WORD = '1;

  fill_state_e       state_q;
  logic [WOFF_W-1:0] cnt_q;
  logic [LINE_W-1:0] line_q;
  logic              way_q;
  logic              in_fill;
  logic              start_fill;

  assign in_fill    = (state_q == ST_FILL);
  assign start_fill = !in_fill && req_i && !lookup_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      line_q  <= '0;
      way_q   <= 1'b0;
    end else if (start_fill) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
      line_q  <= line_i;
      way_q   <= victim_i;
    end else if (in_fill && mem_ack_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_WORD) state_q <= ST_IDLE;
    end
  end

  always_comb begin
    stall_o     = in_fill || (req_i && !lookup_hit_i);
    resp_o      = !in_fill && req_i && lookup_hit_i;
    mem_req_o   = in_fill;
    mem_addr_o  = {line_q, cnt_q, {BYTE_W{1'b0}}};
    wr_en_o     = in_fill && mem_ack_i;
    wr_word_o   = cnt_q;
    commit_o    = wr_en_o && (cnt_q == LAST_WORD);
    fill_line_o = line_q;
    fill_way_o  = way_q;
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SET_W      = 2,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              stall_o,
  output logic              resp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int LINE_W = ADDR_W - WOFF_W - BYTE_W;
  localparam int TAG_W  = LINE_W - SET_W;

  logic [LINE_W-1:0] req_line;
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WOFF_W-1:0] req_word;
  logic              unused_byte_bits;

  assign req_line         = addr_i[ADDR_W-1 -: LINE_W];
  assign req_set          = req_line[SET_W-1:0];
  assign req_tag          = req_line[LINE_W-1 -: TAG_W];
  assign req_word         = addr_i[BYTE_W +: WOFF_W];
  assign unused_byte_bits = ^addr_i[BYTE_W-1:0];

  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] way_valid;
  logic [DATA_W-1:0]   way_rdata [NUM_WAYS];

  logic              wr_en, commit, fill_way, repl_way, victim;
  logic [WOFF_W-1:0] wr_word;
  logic [LINE_W-1:0] fill_line;
  logic [SET_W-1:0]  fill_set;
  logic [TAG_W-1:0]  fill_tag;

  assign fill_set = fill_line[SET_W-1:0];
  assign fill_tag = fill_line[LINE_W-1 -: TAG_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    sa_cache_way #(
      .TAG_W (TAG_W),
      .SET_W (SET_W),
      .WOFF_W(WOFF_W),
      .DATA_W(DATA_W)
    ) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_set_i    (req_set),
      .rd_word_i   (req_word),
      .cmp_tag_i   (req_tag),
      .hit_o       (way_hit[w]),
      .valid_o     (way_valid[w]),
      .rdata_o     (way_rdata[w]),
      .wr_en_i     (wr_en && (fill_way == 1'(w))),
      .wr_set_i    (fill_set),
      .wr_word_i   (wr_word),
      .wr_data_i   (mem_rdata_i),
      .commit_i    (commit && (fill_way == 1'(w))),
      .commit_tag_i(fill_tag)
    );
  end

  // empty way first, way 0 before way 1, then the replacement bit
  assign victim  = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : repl_way);
  assign rdata_o = way_hit[1] ? way_rdata[1] : way_rdata[0];

  sa_cache_lru #(.SET_W(SET_W)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_set_i   (req_set),
    .repl_way_o (repl_way),
    .touch_en_i (resp_o || commit),
    .touch_set_i(commit ? fill_set : req_set),
    .touch_way_i(commit ? fill_way : way_hit[1])
  );

  sa_cache_ctrl #(
    .LINE_W(LINE_W),
    .WOFF_W(WOFF_W),
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .lookup_hit_i(|way_hit),
    .line_i      (req_line),
    .victim_i    (victim),
    .mem_ack_i   (mem_ack_i),
    .stall_o     (stall_o),
    .resp_o      (resp_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .wr_en_o     (wr_en),
    .wr_word_o   (wr_word),
    .commit_o    (commit),
    .fill_line_o (fill_line),
    .fill_way_o  (fill_way)
  );
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int WOFF_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_o,
  input logic              resp_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [1:0]        way_hit_i
);
  localparam logic [WOFF_W-1:0] LAST_WORD = '1;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(1) << BYTE_W;

  p_one_way_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit_i));

  p_stall_in_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (stall_o && !resp_o));

  p_hit_no_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |=> !mem_req_o);

  p_fill_starts_word0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[BYTE_W +: WOFF_W] == '0 && mem_addr_o[BYTE_W-1:0] == '0));

  p_addr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_addr_o[BYTE_W +: WOFF_W] != LAST_WORD)
    |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + WORD_STEP));

  p_hit_after_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_addr_o[BYTE_W +: WOFF_W] == LAST_WORD)
    |=> (resp_o && !mem_req_o));
endmodule

bind sa_cache sa_cache_chk #(
  .ADDR_W(ADDR_W),
  .BYTE_W(BYTE_W),
  .WOFF_W(WOFF_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stall_o   (stall_o),
  .resp_o    (resp_o),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .mem_ack_i (mem_ack_i),
  .way_hit_i (way_hit)
);

// File: tb/sim_sa_cache.sv
`timescale 1ns/1ps
module sim_sa_cache;
  localparam int SETS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        stall, resp, mem_req;
  logic [31:0] rdata, mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  int nlog = 0;
  logic [31:0] mlog [8];

  // reference state derived from the requirements
  bit          m_v   [SETS][2];
  logic [25:0] m_t   [SETS][2];
  bit          m_rep [SETS];

  always #2.5 clk = ~clk;

  sa_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .stall_o(stall), .resp_o(resp), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int set, input int word, input int byt);
    return {26'(tag), 2'(set), 2'(word), 2'(byt)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // memory model: acknowledges after lat waiting cycles, never back to back
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem_word(mem_addr);
        if (nlog < 8) mlog[nlog] = mem_addr;
        nlog++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_v[s][0] = 0; m_v[s][1] = 0; m_rep[s] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R8 reset state
    chk(!stall && !resp && !mem_req, "R8 idle outputs after reset", {29'd0, stall, resp, mem_req}, 32'd0);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic do_access(input logic [31:0] a, input string rq);
    int s;
    logic [25:0] t;
    int hw;
    bit hitw;
    bit v;
    bit stall_ok;
    bit seq_ok;
    logic [31:0] base;
    logic [31:0] exp_d;
    s = int'(a[5:4]);
    t = a[31:6];
    hw = 0;
    hitw = 0;
    for (int w = 0; w < 2; w++) if (m_v[s][w] && m_t[s][w] == t) begin hitw = 1; hw = w; end
    base = {a[31:4], 4'b0};
    exp_d = mem_word({a[31:2], 2'b00});
    @(negedge clk);
    req = 1'b1;
    addr = a;
    nlog = 0;
    #1;
    if (hitw) begin
      chk(resp && !stall && !mem_req, {rq, " R2 hit flags"}, {29'd0, resp, stall, mem_req}, 32'h4);
      chk(rdata == exp_d, {rq, " R2 R1 hit data"}, rdata, exp_d);
      m_rep[s] = !hw[0];
    end else begin
      chk(!resp && stall, {rq, " R3 miss flags"}, {30'd0, resp, stall}, 32'h1);
      stall_ok = 1;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        #1;
        if (resp) break;
        if (!stall) stall_ok = 0;
      end
      chk(stall_ok, {rq, " R3 stall held in fill"}, {31'd0, stall_ok}, 32'd1);
      seq_ok = (nlog == 4);
      for (int k = 0; k < 4; k++) if (nlog == 4 && mlog[k] != base + 32'(4 * k)) seq_ok = 0;
      chk(seq_ok, {rq, " R4 fill address order"}, (nlog == 4) ? mlog[3] : 32'(nlog), base + 32'd12);
      chk(resp && !stall && rdata == exp_d, {rq, " R5 data after fill"}, rdata, exp_d);
      v = !m_v[s][0] ? 1'b0 : (!m_v[s][1] ? 1'b1 : m_rep[s]);
      m_v[s][v] = 1;
      m_t[s][v] = t;
      m_rep[s] = !v;
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input string rq);
    // confirms the model predicts a hit before checking it at the ports
    int s;
    bit h;
    s = int'(a[5:4]);
    h = (m_v[s][0] && m_t[s][0] == a[31:6]) || (m_v[s][1] && m_t[s][1] == a[31:6]);
    chk(h, {rq, " model predicts hit"}, {31'd0, h}, 32'd1);
    do_access(a, rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] seed;
    model_clear();
    do_reset();

    // R6: both empty ways filled, both tags stay resident
    lat = 0;
    do_access(mk(1, 0, 0, 0), "R6");
    do_access(mk(2, 0, 1, 0), "R6");
    expect_hit(mk(1, 0, 2, 0), "R6");
    expect_hit(mk(2, 0, 3, 0), "R6");
    // R7: replacement of the way not touched most recently
    do_access(mk(3, 0, 0, 0), "R7");
    expect_hit(mk(2, 0, 0, 0), "R7");
    do_access(mk(1, 0, 1, 0), "R7");
    expect_hit(mk(2, 0, 2, 0), "R7");
    expect_hit(mk(1, 0, 3, 0), "R7");
    do_access(mk(3, 0, 3, 0), "R7");
    expect_hit(mk(1, 0, 0, 0), "R7");

    // R1: every word and byte offset of a resident line
    lat = 2;
    do_access(mk(9, 2, 0, 0), "R1");
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        expect_hit(mk(9, 2, w, b), "R1");

    // R1: set independence, two tags in every set
    for (int s = 0; s < SETS; s++) begin
      do_access(mk(20 + s, s, 1, 0), "R1");
      do_access(mk(40 + s, s, 2, 0), "R1");
    end
    for (int s = 0; s < SETS; s++) begin
      expect_hit(mk(20 + s, s, 0, 3), "R1");
      expect_hit(mk(40 + s, s, 3, 1), "R1");
    end

    // sweep of small tag space with varying memory latency
    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      lat = int'(seed[25:24]);
      do_access(mk(int'(seed[17:16]), int'(seed[19:18]), int'(seed[21:20]), int'(seed[23:22])), "R2 R7 R9 sweep");
    end

    // R8: reset drops resident lines
    lat = 1;
    do_access(mk(5, 1, 0, 0), "R8");
    expect_hit(mk(5, 1, 1, 0), "R8");
    do_reset();
    do_access(mk(5, 1, 1, 0), "R8 after reset");
    do_access(mk(6, 1, 0, 0), "R8 R6 after reset");
    expect_hit(mk(5, 1, 2, 0), "R8");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule